// File: doc/BRIEF.md
# Flash Self-Programming Control Unit

This unit sits between a processor and its program flash and lets running code erase and rewrite its own flash pages. Software arms a command by writing a control register with the enable bit and at most one command bit set. A store-program strobe must then arrive within a short window, or the armed command lapses. On the strobe the unit starts one of five actions:

- a page-buffer load;
- a page erase;
- a page write;
- a re-enable of the read-while-write section;
- a lock-bit update.

Array operations go out on a simple request/op/address interface and end when the array returns a done pulse.

Erase and write operations aimed at the read-while-write section set a sticky busy flag. While the flag is set, reads of that section are forced to all ones. The flag clears on an explicit re-enable command or when software starts loading the page buffer. A ready interrupt pulses when an operation completes. Erase and write requests are refused while an EEPROM write is in progress, and the EEPROM is held off while an erase or write is running.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset the control readback is zero, the busy flag is clear, the lock bits read 1111, and `fl_req_o` and `irq_o` are low.
- R2: A command armed by a control write executes only if `spm_i` is high on one of the four clock edges after the write edge. Otherwise the command lapses and readback bit 0 (enable) returns to 0.
- R3: A control write with enable set is ignored while enable already reads 1. A write that sets more than one command bit is also ignored.
- R4: Control bit positions are: 0 enable, 1 erase, 2 write, 3 lock, 4 re-enable, 5 interrupt enable. Readback bit 6 is the busy flag.
  - An erase or write raises `fl_req_o` with `fl_op_o` equal to 1 for erase or 2 for write.
  - `fl_page_o` carries `zptr_i[15:6]`, the 64-byte page number.
  - Enable reads 1 until the edge on which `fl_done_i` is seen, then reads 0.
- R5: An erase or write with `zptr_i` below `RWW_LIMIT` sets the busy flag. One at or above the limit leaves the flag unchanged.
- R6: While the busy flag is set, `rd_data_o` is 16'hFFFF for any `rd_addr_i` below `RWW_LIMIT`. Other addresses pass `rd_data_i` through. The flag stays set after the operation completes.
- R7: The re-enable command clears the busy flag without array access, ignoring `zptr_i` and `data_i`, and enable returns to 0.
- R8: A strobe with enable alone (no command bit) loads the page buffer. It issues `fl_op_o` = 0 with `fl_offs_o` = `zptr_i[5:0]` and `fl_data_o` = `data_i`, and clears the busy flag.
- R9: With interrupt enable set, `irq_o` pulses high for exactly one cycle after each completed operation. With it clear, `irq_o` stays low. A write with enable clear updates only the interrupt-enable bit.
- R10: An erase or write strobed while `ee_busy_i` is high is refused: no array request is made, the busy flag is unchanged and enable returns to 0. `ee_block_o` is high while an erase or write is running.
- R11: The lock command ANDs `data_i[3:0]` into the lock bits, so a lock bit can go from 1 to 0 but never back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control register write data |
| ctl_rdata_o | output | 7 | Control readback, busy flag in bit 6 |
| spm_i | input | 1 | Store-program strobe |
| zptr_i | input | 16 | Flash byte address pointer |
| data_i | input | 16 | Data word for buffer load or lock update |
| ee_busy_i | input | 1 | EEPROM write in progress |
| ee_block_o | output | 1 | Holds off EEPROM writes during erase or write |
| fl_req_o | output | 1 | Array operation request |
| fl_op_o | output | 2 | Array operation: 0 buffer load, 1 erase, 2 write |
| fl_page_o | output | 10 | Page number |
| fl_offs_o | output | 6 | Byte offset inside the page |
| fl_data_o | output | 16 | Buffer load data |
| fl_done_i | input | 1 | Array operation finished |
| rd_addr_i | input | 16 | Flash read byte address |
| rd_data_i | input | 16 | Raw array read data |
| rd_data_o | output | 16 | Read data after section masking |
| lock_o | output | 4 | Protection bits |
| irq_o | output | 1 | Ready interrupt pulse |

## Verification
The checker watches several properties on every cycle:
- lock bits never rise;
- the read mask always returns all ones for the busy section;
- the interrupt is a single-cycle pulse that follows a drop of enable;
- an array request only exists while enable reads 1 and is held until done;
- no erase or write request begins after an EEPROM-busy cycle.

Some behaviours need a chosen stimulus and are shown only by the directed scenarios:
- the exact edges of the four-cycle arming window and the lapse after it;
- the rejection of a second arm attempt;
- the busy flag surviving completion and then clearing by re-enable or buffer load;
- the section boundary test on the pointer.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    OP_BUF   = 2'd0,
    OP_ERASE = 2'd1,
    OP_WRITE = 2'd2
  } fl_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2
  } spm_state_e;

  // command field after dropping the enable bit
  localparam int unsigned CMD_ERASE = 0;
  localparam int unsigned CMD_WRITE = 1;
  localparam int unsigned CMD_LOCK  = 2;
  localparam int unsigned CMD_REEN  = 3;
  localparam int unsigned CMD_W     = 4;
endpackage

// File: rtl/spm_arm_window.sv
module spm_arm_window #(
  parameter int unsigned WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic spm_i,
  output logic fire_o,
  output logic lapse_o
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q;
  logic          armed;

  assign armed   = (cnt_q != '0);
  assign fire_o  = armed && spm_i;
  assign lapse_o = armed && !spm_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(WIN);
    else if (fire_o)  cnt_q <= '0;
    else if (armed)   cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/spm_lock_reg.sv
module spm_lock_reg #(
  parameter int unsigned LOCK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LOCK_W-1:0] data_i,
  output logic [LOCK_W-1:0] lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_o <= '1;
    else if (wr_i) lock_o <= lock_o & data_i;  // program-only: 1 -> 0
  end
endmodule

// File: rtl/spm_rww_mask.sv
module spm_rww_mask #(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        DATA_W    = 16,
  parameter logic [ADDR_W-1:0]  RWW_LIMIT = 16'hE000
) (
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    if (busy_i && (addr_i < RWW_LIMIT)) data_o = '1;
    else                                data_o = data_i;
  end
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import spm_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       DATA_W     = 16,
  parameter int unsigned       PAGE_BYTES = 64,
  parameter int unsigned       ARM_WIN    = 4,
  parameter int unsigned       LOCK_W     = 4,
  parameter logic [ADDR_W-1:0] RWW_LIMIT  = 16'hE000,
  localparam int unsigned      OFFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned      PAGE_W     = ADDR_W - OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [5:0]        ctl_wdata_i,
  output logic [6:0]        ctl_rdata_o,
  input  logic              spm_i,
  input  logic [ADDR_W-1:0] zptr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ee_busy_i,
  output logic              ee_block_o,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic [PAGE_W-1:0] fl_page_o,
  output logic [OFFS_W-1:0] fl_offs_o,
  output logic [DATA_W-1:0] fl_data_o,
  input  logic              fl_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic              irq_o
);
  spm_state_e        state_q;
  logic              en_q, irq_en_q, busy_q, irq_q;
  logic [CMD_W-1:0]  cmd_q;
  fl_op_e            op_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] wdat_q;

  logic arm_ok, fire, lapse, exec, lock_wr, in_rww, pg_cmd;

  assign arm_ok  = ctl_wr_i && ctl_wdata_i[0] && !en_q
                && ($countones(ctl_wdata_i[4:1]) <= 1);
  assign exec    = (state_q == ST_ARMED) && fire;
  assign pg_cmd  = cmd_q[CMD_ERASE] || cmd_q[CMD_WRITE];
  assign lock_wr = exec && cmd_q[CMD_LOCK];
  assign in_rww  = zptr_i < RWW_LIMIT;

  spm_arm_window #(.WIN(ARM_WIN)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (arm_ok),
    .spm_i   (spm_i),
    .fire_o  (fire),
    .lapse_o (lapse)
  );

  spm_lock_reg #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (lock_wr),
    .data_i (data_i[LOCK_W-1:0]),
    .lock_o (lock_o)
  );

  spm_rww_mask #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RWW_LIMIT(RWW_LIMIT)) u_mask (
    .busy_i (busy_q),
    .addr_i (rd_addr_i),
    .data_i (rd_data_i),
    .data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      en_q     <= 1'b0;
      cmd_q    <= '0;
      irq_en_q <= 1'b0;
      busy_q   <= 1'b0;
      irq_q    <= 1'b0;
      op_q     <= OP_BUF;
      page_q   <= '0;
      offs_q   <= '0;
      wdat_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (ctl_wr_i && !ctl_wdata_i[0]) irq_en_q <= ctl_wdata_i[5];
      unique case (state_q)
        ST_IDLE: begin
          if (arm_ok) begin
            en_q     <= 1'b1;
            cmd_q    <= ctl_wdata_i[4:1];
            irq_en_q <= ctl_wdata_i[5];
            state_q  <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (fire) begin
            if (pg_cmd) begin
              if (ee_busy_i) begin  // refused: EEPROM write in flight
                en_q    <= 1'b0;
                cmd_q   <= '0;
                state_q <= ST_IDLE;
              end else begin
                op_q    <= cmd_q[CMD_ERASE] ? OP_ERASE : OP_WRITE;
                page_q  <= zptr_i[ADDR_W-1:OFFS_W];
                busy_q  <= busy_q || in_rww;
                state_q <= ST_WAIT;
              end
            end else if (cmd_q[CMD_LOCK] || cmd_q[CMD_REEN]) begin
              if (cmd_q[CMD_REEN]) busy_q <= 1'b0;
              en_q    <= 1'b0;
              cmd_q   <= '0;
              irq_q   <= irq_en_q;
              state_q <= ST_IDLE;
            end else begin
              busy_q  <= 1'b0;  // buffer load re-opens the section
              op_q    <= OP_BUF;
              offs_q  <= zptr_i[OFFS_W-1:0];
              wdat_q  <= data_i;
              state_q <= ST_WAIT;
            end
          end else if (lapse) begin
            en_q    <= 1'b0;
            cmd_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (fl_done_i) begin
            en_q    <= 1'b0;
            cmd_q   <= '0;
            irq_q   <= irq_en_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fl_req_o    = (state_q == ST_WAIT);
  assign ee_block_o  = fl_req_o && (op_q != OP_BUF);
  assign fl_op_o     = op_q;
  assign fl_page_o   = page_q;
  assign fl_offs_o   = offs_q;
  assign fl_data_o   = wdat_q;
  assign irq_o       = irq_q;
  assign ctl_rdata_o = {busy_q, irq_en_q, cmd_q, en_q};
endmodule

// File: rtl/flash_selfprog_ctrl_chk.sv
module flash_selfprog_ctrl_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       LOCK_W    = 4,
  parameter logic [ADDR_W-1:0] RWW_LIMIT = 16'hE000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [6:0]        ctl_rdata_o,
  input logic              ee_busy_i,
  input logic              fl_req_o,
  input logic [1:0]        fl_op_o,
  input logic              fl_done_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [LOCK_W-1:0] lock_o,
  input logic              irq_o
);
  AST_REQ_WITH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> ctl_rdata_o[0]);  // R4

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_done_i) |=> fl_req_o);  // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);  // R9

  AST_IRQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!ctl_rdata_o[0] && $past(ctl_rdata_o[0])));  // R9

  AST_LOCK_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_o & ~$past(lock_o)) == '0));  // R11

  AST_RWW_READS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[6] && (rd_addr_i < RWW_LIMIT)) |-> (rd_data_o == '1));  // R6

  AST_EE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fl_req_o) && (fl_op_o != 2'd0)) |-> !$past(ee_busy_i));  // R10
endmodule

bind flash_selfprog_ctrl flash_selfprog_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_W(LOCK_W), .RWW_LIMIT(RWW_LIMIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_rdata_o (ctl_rdata_o),
  .ee_busy_i   (ee_busy_i),
  .fl_req_o    (fl_req_o),
  .fl_op_o     (fl_op_o),
  .fl_done_i   (fl_done_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .lock_o      (lock_o),
  .irq_o       (irq_o)
);

// File: tb/flash_selfprog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ctl_wr_i = 1'b0, spm_i = 1'b0, ee_busy_i = 1'b0, fl_done_i = 1'b0;
  logic [5:0]  ctl_wdata_i = '0;
  logic [6:0]  ctl_rdata_o;
  logic [15:0] zptr_i = '0, data_i = '0, rd_addr_i = '0, rd_data_i = 16'h1234;
  logic [15:0] fl_data_o, rd_data_o;
  logic        ee_block_o, fl_req_o, irq_o;
  logic [1:0]  fl_op_o;
  logic [9:0]  fl_page_o;
  logic [5:0]  fl_offs_o;
  logic [3:0]  lock_o;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk_i = ~clk_i;

  flash_selfprog_ctrl u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [5:0] v);
    ctl_wdata_i = v; ctl_wr_i = 1'b1;
    @(negedge clk_i);
    ctl_wr_i = 1'b0;
  endtask

  // strobe lands on the d-th edge after the control write edge
  task automatic strobe(int d);
    repeat (d - 1) @(negedge clk_i);
    spm_i = 1'b1;
    @(negedge clk_i);
    spm_i = 1'b0;
  endtask

  task automatic finish_op();
    fl_done_i = 1'b1;
    @(negedge clk_i);
    fl_done_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctl", ctl_rdata_o, 0);
    check("R1 lock", lock_o, 4'hF);
    check("R1 req", fl_req_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_erase_rww();
    wr_ctl(6'h20);
    zptr_i = 16'h0140;
    wr_ctl(6'h23);
    strobe(4);  // last edge inside the window, R2
    check("R2 fire at edge 4", fl_req_o, 1);
    check("R4 op", fl_op_o, 1);
    check("R4 page", fl_page_o, 10'd5);
    check("R4 en held", ctl_rdata_o[0], 1);
    check("R5 busy set", ctl_rdata_o[6], 1);
    check("R10 ee block", ee_block_o, 1);
    wr_ctl(6'h09);
    check("R3 second arm ignored", ctl_rdata_o[3:0], 4'b0011);
    rd_addr_i = 16'h0100; #1;
    check("R6 rww masked", rd_data_o, 16'hFFFF);
    rd_addr_i = 16'hF000; #1;
    check("R6 nrww pass", rd_data_o, 16'h1234);
    finish_op();
    check("R4 en cleared", ctl_rdata_o[0], 0);
    check("R9 irq pulse", irq_o, 1);
    @(negedge clk_i);
    check("R9 irq one cycle", irq_o, 0);
    rd_addr_i = 16'h0100; #1;
    check("R6 sticky after done", rd_data_o, 16'hFFFF);
  endtask

  task automatic t_reen();
    zptr_i = 16'h0000; data_i = 16'hFFFF;
    wr_ctl(6'h31);
    strobe(1);
    check("R7 busy cleared", ctl_rdata_o[6], 0);
    check("R7 en cleared", ctl_rdata_o[0], 0);
    check("R7 no array req", fl_req_o, 0);
    check("R9 irq after reen", irq_o, 1);
    rd_addr_i = 16'h0100; #1;
    check("R7 rww readable", rd_data_o, 16'h1234);
  endtask

  task automatic t_lapse();
    zptr_i = 16'h0200;
    wr_ctl(6'h23);
    strobe(5);
    check("R2 lapsed no req", fl_req_o, 0);
    check("R2 lapsed en", ctl_rdata_o[0], 0);
    check("R2 lapsed busy", ctl_rdata_o[6], 0);
  endtask

  task automatic t_nrww_write();
    zptr_i = 16'hF040;
    wr_ctl(6'h25);
    strobe(2);
    check("R4 write op", fl_op_o, 2);
    check("R4 write page", fl_page_o, 10'h3C1);
    check("R5 nrww no busy", ctl_rdata_o[6], 0);
    finish_op();
    check("R4 write done", ctl_rdata_o[0], 0);
  endtask

  task automatic t_bufload();
    zptr_i = 16'h0040;
    wr_ctl(6'h23);
    strobe(1);
    finish_op();
    check("R5 busy before load", ctl_rdata_o[6], 1);
    zptr_i = 16'h0006; data_i = 16'hBEEF;
    wr_ctl(6'h21);
    strobe(3);
    check("R8 buf op", fl_op_o, 0);
    check("R8 offs", fl_offs_o, 6'd6);
    check("R8 data", fl_data_o, 16'hBEEF);
    check("R8 busy cleared", ctl_rdata_o[6], 0);
    check("R10 no block on load", ee_block_o, 0);
    finish_op();
  endtask

  task automatic t_ee_conflict();
    ee_busy_i = 1'b1;
    zptr_i = 16'h0080;
    wr_ctl(6'h23);
    strobe(1);
    check("R10 refused no req", fl_req_o, 0);
    check("R10 refused en", ctl_rdata_o[0], 0);
    check("R10 refused busy", ctl_rdata_o[6], 0);
    check("R10 refused irq", irq_o, 0);
    ee_busy_i = 1'b0;
  endtask

  task automatic t_lock();
    wr_ctl(6'h00);
    check("R9 irq_en cleared", ctl_rdata_o[5], 0);
    data_i = 16'h000E;
    wr_ctl(6'h09);
    strobe(1);
    check("R11 lock 1110", lock_o, 4'hE);
    check("R9 no irq when off", irq_o, 0);
    data_i = 16'h000D;
    wr_ctl(6'h09);
    strobe(2);
    check("R11 no 0->1", lock_o, 4'hC);
    wr_ctl(6'h07);
    check("R3 multi cmd ignored", ctl_rdata_o[0], 0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_erase_rww();
    t_reen();
    t_lapse();
    t_nrww_write();
    t_bufload();
    t_ee_conflict();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule